// File: doc/BRIEF.md
# Host/Sub-Processor Byte Mailbox

This block passes single bytes in both directions between a host bus and a sub-processor. The host sees two registers: a data register and a status register. A byte the host writes to the data register is held for the sub side. A byte the sub side writes is held for the host. Three handshake flags govern the exchange:

- a sub-idle flag, which is the inverse of the sub side's "reading" level;
- an inbound-full flag, set while a byte waits for the sub side;
- an outbound-full flag, set while a byte waits for the host.

The host may write data only while the sub side is idle and the inbound slot is empty. Any other write is dropped, and a sticky overrun output records it.

After system reset the block holds its sub-system reset output low for a parameterised number of cycles. The default is 2001 cycles, which is just over 10 µs at 200 MHz. While that output is low, every access is refused. A constant-low output tells the host that the option is fitted.

Top module: `mbx_top`

## Requirements
- R1: After `rst_n` is released, `sub_rst_n` stays low and rises on clock edge SYNC_STAGES+RST_CYCLES after the release (2+2001 by default). Once high, it stays high until `rst_n` is asserted again.
- R2: While `sub_rst_n` is low, every host and sub strobe is ignored and `host_rdata` reads 0. When `sub_rst_n` rises, both full flags and the overrun output are 0 and `sub_rdata` is 0.
- R3: With `host_addr` = 4'hF, `host_rdata` is the status byte: bit2 = NOT `sub_reading`, bit1 = inbound full, bit0 = outbound full, bits 7..3 = 0.
- R4: A host write to 4'hE while `sub_reading`=0 and inbound is empty stores the byte. After that edge the byte appears on `sub_rdata` and inbound full is 1.
- R5: A host write to 4'hE while inbound is full or `sub_reading`=1 is dropped and leaves `sub_rdata` and the flags unchanged. It sets `host_overrun`, which stays 1 until `rst_n` is asserted.
- R6: `sub_rd` while inbound is full clears inbound full. `sub_rd` while it is empty changes nothing.
- R7: `sub_wr` stores `sub_wdata` and sets outbound full. With `host_addr` = 4'hE, `host_rdata` shows the stored byte. `host_rd` at 4'hE while outbound is full clears the flag. `host_rd` while it is empty changes nothing.
- R8: When `sub_wr` and a host data read fall in the same cycle, the host sees the old byte in that cycle. Outbound full stays 1 and holds the new byte.
- R9: Host writes to offsets other than 4'hE change no state. Reads from offsets other than 4'hE and 4'hF return 0.
- R10: `opt_fitted_n` is constantly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| host_addr | input | 4 | Host register offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Host read byte (combinational) |
| host_overrun | output | 1 | Sticky dropped-write flag |
| sub_reading | input | 1 | Level: sub side is busy reading |
| sub_rd | input | 1 | Sub side takes the inbound byte |
| sub_rdata | output | DATA_W | Inbound byte |
| sub_wr | input | 1 | Sub side posts a byte to the host |
| sub_wdata | input | DATA_W | Byte posted by the sub side |
| sub_rst_n | output | 1 | Timed active-low reset to the sub system |
| opt_fitted_n | output | 1 | Active-low presence indication |

## Verification
The cycles that can collide are a sub-side post and a host data read that consumes the outbound slot. The bench forces this pairing in a directed case. It then checks that the host sees the previous byte in that cycle and that the flag stays set, now holding the new byte. Random traffic raises both strobes together again and again, and a bench model applies the rule that a post wins over a consume. A dropped host write in the same cycle as a sub read is also produced randomly and judged the same way.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFF_DATA = 4'hE;
  localparam logic [ADDR_W-1:0] OFF_STAT = 4'hF;
  localparam int ST_IDLE = 2;
  localparam int ST_INB  = 1;
  localparam int ST_OUTB = 0;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_rst_timer.sv
module mbx_rst_timer #(
  parameter int CYCLES = 2001
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!done_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] dout
);
  logic         full_q, full_d;
  logic [W-1:0] data_q, data_d;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (take) full_d = 1'b0;
    if (load) begin
      full_d = 1'b1;
      data_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (load) data_q <= data_d;
    end
  end

  assign full = full_q;
  assign dout = data_q;
endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int RST_CYCLES  = 2001,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_overrun,
  input  logic              sub_reading,
  input  logic              sub_rd,
  output logic [DATA_W-1:0] sub_rdata,
  input  logic              sub_wr,
  input  logic [DATA_W-1:0] sub_wdata,
  output logic              sub_rst_n,
  output logic              opt_fitted_n
);
  logic              rst_int_n;
  logic              en;
  logic              hit_data, hit_stat, idle;
  logic              in_load, in_take, out_load, out_take;
  logic              ibf_q, obf_q;
  logic [DATA_W-1:0] in_byte, out_byte, status;
  logic              ovr_q, ovr_d, ovr_set;

  mbx_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_int_n)
  );

  mbx_rst_timer #(.CYCLES(RST_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .done(en)
  );

  assign hit_data = (host_addr == OFF_DATA);
  assign hit_stat = (host_addr == OFF_STAT);
  assign idle     = ~sub_reading;

  assign in_load  = en & host_wr & hit_data & idle & ~ibf_q;
  assign ovr_set  = en & host_wr & hit_data & ~(idle & ~ibf_q);
  assign in_take  = en & sub_rd & ibf_q;
  assign out_load = en & sub_wr;
  assign out_take = en & host_rd & hit_data & obf_q;

  mbx_slot #(.W(DATA_W)) u_inbound (
    .clk(clk), .rst_n(rst_int_n), .load(in_load), .din(host_wdata),
    .take(in_take), .full(ibf_q), .dout(in_byte)
  );

  mbx_slot #(.W(DATA_W)) u_outbound (
    .clk(clk), .rst_n(rst_int_n), .load(out_load), .din(sub_wdata),
    .take(out_take), .full(obf_q), .dout(out_byte)
  );

  always_comb begin
    ovr_d = ovr_q;
    if (ovr_set) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ovr_q <= 1'b0;
    else            ovr_q <= ovr_d;
  end

  always_comb begin
    status          = '0;
    status[ST_IDLE] = idle;
    status[ST_INB]  = ibf_q;
    status[ST_OUTB] = obf_q;
  end

  always_comb begin
    host_rdata = '0;
    if (en) begin
      if (hit_data)      host_rdata = out_byte;
      else if (hit_stat) host_rdata = status;
    end
  end

  assign host_overrun = ovr_q;
  assign sub_rdata    = in_byte;
  assign sub_rst_n    = en;
  assign opt_fitted_n = 1'b0;
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk
  import mbx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic [DATA_W-1:0] host_rdata,
  input logic              host_overrun,
  input logic              sub_reading,
  input logic              sub_rd,
  input logic [DATA_W-1:0] sub_rdata,
  input logic              sub_wr,
  input logic              sub_rst_n,
  input logic              ibf_q,
  input logic              obf_q
);
  AST_SUB_RST_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    sub_rst_n |=> sub_rst_n); // R1
  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_rst_n |-> (!ibf_q && !obf_q && !host_overrun)); // R2
  AST_STAT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == OFF_STAT) |-> (host_rdata[DATA_W-1:3] == '0)); // R3
  AST_IBF_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibf_q) |-> $past(host_wr && host_addr == OFF_DATA && !sub_reading)); // R4
  AST_BLOCKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_rst_n && host_wr && host_addr == OFF_DATA && (ibf_q || sub_reading))
      |=> ($stable(sub_rdata) && host_overrun)); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    host_overrun |=> host_overrun); // R5
  AST_IBF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ibf_q) |-> $past(sub_rd)); // R6
  AST_OBF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(obf_q) |-> $past(host_rd && host_addr == OFF_DATA)); // R7
  AST_POST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_rst_n && sub_wr && host_rd) |=> obf_q); // R8
endmodule

bind mbx_top mbx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_rd(host_rd), .host_rdata(host_rdata), .host_overrun(host_overrun),
  .sub_reading(sub_reading), .sub_rd(sub_rd), .sub_rdata(sub_rdata),
  .sub_wr(sub_wr), .sub_rst_n(sub_rst_n), .ibf_q(ibf_q), .obf_q(obf_q)
);

// File: tb/tb_mbx_top.sv
`timescale 1ns/1ps
module tb_mbx_top;
  localparam int RSTC = 2001;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] host_addr;
  logic       host_wr, host_rd;
  logic [7:0] host_wdata, host_rdata;
  logic       host_overrun;
  logic       sub_reading, sub_rd, sub_wr;
  logic [7:0] sub_rdata, sub_wdata;
  logic       sub_rst_n, opt_fitted_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bit       m_ibf, m_obf, m_ovr;
  bit [7:0] m_in, m_out;

  always #2.5 clk = ~clk;

  mbx_top dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_overrun(host_overrun), .sub_reading(sub_reading), .sub_rd(sub_rd),
    .sub_rdata(sub_rdata), .sub_wr(sub_wr), .sub_wdata(sub_wdata),
    .sub_rst_n(sub_rst_n), .opt_fitted_n(opt_fitted_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [3:0] a, input bit reading);
    if (a == 4'hE) return m_out;
    if (a == 4'hF) return {5'b0, ~reading, m_ibf, m_obf};
    return 8'h00;
  endfunction

  task automatic idle_inputs();
    host_wr = 0; host_rd = 0; sub_rd = 0; sub_wr = 0;
  endtask

  // One cycle: called just after a negedge; leaves at the next negedge.
  task automatic step(input bit wr, input bit rd, input bit srd, input bit swr,
                      input bit reading, input logic [3:0] a,
                      input logic [7:0] wd, input logic [7:0] sd);
    bit hw_data, ok, load_in, take_in, take_out;
    host_wr = wr; host_rd = rd; sub_rd = srd; sub_wr = swr;
    sub_reading = reading; host_addr = a; host_wdata = wd; sub_wdata = sd;
    #1;
    chk(host_rdata == exp_rd(a, reading), "R3 R7 R9 host_rdata", host_rdata,
        exp_rd(a, reading));
    @(posedge clk);
    hw_data  = wr && (a == 4'hE);
    ok       = !reading && !m_ibf;
    load_in  = hw_data && ok;
    take_in  = srd && m_ibf;
    take_out = rd && (a == 4'hE) && m_obf;
    if (hw_data && !ok) m_ovr = 1;
    if (take_in) m_ibf = 0;
    if (load_in) begin m_ibf = 1; m_in = wd; end
    if (take_out) m_obf = 0;
    if (swr) begin m_obf = 1; m_out = sd; end
    @(negedge clk);
    idle_inputs();
    chk(sub_rdata == m_in, "R4 R5 sub_rdata", sub_rdata, m_in);
    chk(host_overrun == m_ovr, "R5 host_overrun", host_overrun, m_ovr);
  endtask

  task automatic stat_is(input logic [7:0] exp, input string req);
    host_addr = 4'hF; #1;
    chk(host_rdata == exp, req, host_rdata, exp);
  endtask

  task automatic apply_reset();
    rst_n = 0; idle_inputs(); sub_reading = 0; host_addr = 4'hF;
    host_wdata = 0; sub_wdata = 0;
    m_ibf = 0; m_obf = 0; m_ovr = 0; m_in = 0; m_out = 0;
    repeat (3) @(negedge clk);
    chk(sub_rst_n == 1'b0, "R1 sub_rst_n in reset", sub_rst_n, 0);
    chk(host_rdata == 8'h00, "R2 rdata in reset", host_rdata, 0);
    rst_n = 1;
    for (int e = 1; e <= SYNC + RSTC; e++) begin
      // strobes throughout the hold window must be ignored (R2)
      if (e < SYNC + RSTC - 1) begin
        host_wr = 1; host_addr = 4'hE; host_wdata = 8'hAA;
        sub_wr = 1; sub_wdata = 8'h55; sub_rd = 1; host_rd = 1;
      end else begin
        idle_inputs(); host_addr = 4'hF;
      end
      @(posedge clk);
      @(negedge clk);
      if (e == SYNC + RSTC - 1)
        chk(sub_rst_n == 1'b0, "R1 still low", sub_rst_n, 0);
      if (e == SYNC + RSTC)
        chk(sub_rst_n == 1'b1, "R1 released", sub_rst_n, 1);
    end
    idle_inputs();
    stat_is(8'h04, "R2 flags clear after hold");
    chk(host_overrun == 1'b0, "R2 overrun clear", host_overrun, 0);
    chk(sub_rdata == 8'h00, "R2 sub_rdata clear", sub_rdata, 0);
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    apply_reset();
    chk(opt_fitted_n == 1'b0, "R10 presence", opt_fitted_n, 0);

    step(1, 0, 0, 0, 0, 4'hE, 8'h3C, 8'h00);          // R4 accepted write
    stat_is(8'h06, "R4 inbound full");
    step(1, 0, 0, 0, 0, 4'hE, 8'h99, 8'h00);          // R5 inbound full
    stat_is(8'h06, "R5 flags unchanged");
    chk(host_overrun == 1'b1, "R5 overrun set", host_overrun, 1);
    step(0, 0, 1, 0, 0, 4'hF, 8'h00, 8'h00);          // R6 take
    stat_is(8'h04, "R6 inbound cleared");
    step(0, 0, 1, 0, 0, 4'hF, 8'h00, 8'h00);          // R6 take when empty
    stat_is(8'h04, "R6 no effect when empty");
    step(1, 0, 0, 0, 1, 4'hE, 8'h11, 8'h00);          // R5 sub reading
    sub_reading = 1;
    stat_is(8'h00, "R5 R3 reading blocks write");
    sub_reading = 0;
    chk(sub_rdata == 8'h3C, "R5 byte kept", sub_rdata, 8'h3C);
    step(0, 0, 0, 1, 0, 4'hF, 8'h00, 8'hC3);          // R7 post
    stat_is(8'h05, "R7 outbound full");
    host_addr = 4'hE; #1;
    chk(host_rdata == 8'hC3, "R7 posted byte", host_rdata, 8'hC3);
    step(0, 1, 0, 0, 0, 4'hE, 8'h00, 8'h00);          // R7 consume
    stat_is(8'h04, "R7 outbound cleared");
    step(0, 1, 0, 0, 0, 4'hE, 8'h00, 8'h00);          // R7 read when empty
    stat_is(8'h04, "R7 no effect when empty");
    step(0, 0, 0, 1, 0, 4'hF, 8'h00, 8'h5A);
    step(0, 1, 0, 1, 0, 4'hE, 8'h00, 8'hA5);          // R8 collision
    stat_is(8'h05, "R8 outbound stays full");
    host_addr = 4'hE; #1;
    chk(host_rdata == 8'hA5, "R8 new byte held", host_rdata, 8'hA5);
    step(1, 0, 0, 0, 0, 4'h3, 8'h77, 8'h00);          // R9 other offset
    stat_is(8'h05, "R9 no state change");
    host_addr = 4'h3; #1;
    chk(host_rdata == 8'h00, "R9 other offset reads 0", host_rdata, 0);

    for (int i = 0; i < 400; i++) begin
      logic [3:0] a;
      int pick;
      pick = $urandom_range(0, 9);
      a = (pick < 5) ? 4'hE : (pick < 8) ? 4'hF : 4'($urandom_range(0, 15));
      step($urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
           $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 3) == 0, a, 8'($urandom), 8'($urandom));
    end

    apply_reset();                                    // R1 R2 second pass
    step(1, 0, 0, 0, 0, 4'hE, 8'h42, 8'h00);
    stat_is(8'h06, "R4 after second reset");
    summary();
  end
endmodule